// File: doc/BRIEF.md
# Partial-Width Aliased Register File

A sixteen-entry, 64-bit general register file with one write port and one read port. Each port carries a register index, a two-bit size code and an extension-prefix flag. Together these decide which register and which bits are reached. Accesses of 64, 32 or 16 bits always use the low end of a register.

Byte accesses follow two selector maps, and the prefix flag picks between them:
- With the prefix clear, selectors 0–3 reach bits 7:0 of registers 0–3, and selectors 4–7 reach bits 15:8 of those same four registers.
- With the prefix set, every selector n reaches bits 7:0 of register n. This includes the stack, frame and index registers 4–7 and the extended registers 8–15.

Read data is returned right-aligned and zero-extended. A high-byte read is moved down into bits 7:0.

A separate pure-combinational check port takes two byte-operand codes from one operation. It reports a pairing that cannot be encoded: a high byte together with a byte register that only exists under the prefix.

The ports are plain, with no valid/ready handshake. Every write completes at the next rising edge and every read completes in the same cycle, so the block never has a reason to push back.

Top module: `aliasreg_file`

## Requirements
- R1: With `rst` high at a rising edge, all sixteen registers become zero.
- R2: With the prefix clear, index bit 3 is ignored for every size. Byte selectors 0–3 reach bits 7:0 of registers 0–3, and byte selectors 4–7 reach bits 15:8 of registers 0–3 in the same order.
- R3: With the prefix set, a byte access with selector n (0–15) reaches bits 7:0 of register n.
- R4: A high-byte read returns register bits 15:8 in `rd_data[7:0]`, with all other bits zero.
- R5: Reads are right-aligned and zero-extended. Size code 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits.
- R6: Writes of 8 and 16 bits change only the addressed lanes. A high-byte write takes its value from `wr_data[7:0]`.
- R7: A 32-bit write clears bits 63:32 of the destination. A 64-bit write replaces all bits.
- R8: A read of the register being written in the same cycle returns the value the write will leave.
- R9: Check codes 0–15 name bits 7:0 of register n, and codes 16–19 name bits 15:8 of registers 0–3. `chk_err` rises when one code is a high byte and the other is a low byte of register 4–15. It also rises when either code is 20 or above. Any other pairing gives no error.
- R10: While `wr_en` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write register or byte selector |
| wr_size | input | 2 | Write size code |
| wr_pfx | input | 1 | Write extension-prefix flag |
| wr_data | input | 64 | Write value, right-aligned |
| rd_idx | input | 4 | Read register or byte selector |
| rd_size | input | 2 | Read size code |
| rd_pfx | input | 1 | Read extension-prefix flag |
| rd_data | output | 64 | Read value, right-aligned, zero-extended |
| chk_a | input | 5 | First byte-operand code |
| chk_b | input | 5 | Second byte-operand code |
| chk_err | output | 1 | Illegal byte-operand pairing |

## Verification
A wrong lane merge or a wrong selector decode corrupts a register quietly. It shows at the ports only on a later read of the damaged lanes, at the earliest one edge after the faulty write, so each write is followed by reads at several widths and through both selector maps. A bad bypass path shows in the same cycle as the write. A bad pairing rule shows on `chk_err` at once, because that path holds no state.

// File: rtl/aliasreg_pkg.sv
`timescale 1ns/1ps
package aliasreg_pkg;
  typedef enum logic [1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZ64 = 2'd3
  } size_e;

  localparam int LEGACY_HI_REGS = 4;
endpackage

// File: rtl/aliasreg_decode.sv
`timescale 1ns/1ps
module aliasreg_decode #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       size,
  input  logic             pfx,
  output logic [IDX_W-1:0] reg_sel,
  output logic             hi
);
  import aliasreg_pkg::*;

  always_comb begin
    reg_sel = pfx ? idx : {1'b0, idx[IDX_W-2:0]};
    hi      = 1'b0;
    if (size_e'(size) == SZ8 && !pfx && idx[2]) begin
      reg_sel = {{(IDX_W-2){1'b0}}, idx[1:0]};
      hi      = 1'b1;
    end
  end
endmodule

// File: rtl/aliasreg_merge.sv
`timescale 1ns/1ps
module aliasreg_merge #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] din,
  input  logic [1:0]    size,
  input  logic          hi,
  output logic [DW-1:0] new_val
);
  import aliasreg_pkg::*;
  localparam int BW = 8;
  localparam int HW = 16;
  localparam int WW = 32;

  always_comb begin
    new_val = old_val;
    case (size_e'(size))
      SZ8: begin
        if (hi) new_val[HW-1:BW] = din[BW-1:0];
        else    new_val[BW-1:0]  = din[BW-1:0];
      end
      SZ16:    new_val[HW-1:0] = din[HW-1:0];
      SZ32:    new_val = {{(DW-WW){1'b0}}, din[WW-1:0]};
      default: new_val = din;
    endcase
  end
endmodule

// File: rtl/aliasreg_align.sv
`timescale 1ns/1ps
module aliasreg_align #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] raw,
  input  logic [1:0]    size,
  input  logic          hi,
  output logic [DW-1:0] dout
);
  import aliasreg_pkg::*;
  localparam int BW = 8;
  localparam int HW = 16;
  localparam int WW = 32;

  logic [DW-1:0] shifted;

  always_comb begin
    shifted = hi ? (raw >> BW) : raw;
    case (size_e'(size))
      SZ8:     dout = {{(DW-BW){1'b0}}, shifted[BW-1:0]};
      SZ16:    dout = {{(DW-HW){1'b0}}, shifted[HW-1:0]};
      SZ32:    dout = {{(DW-WW){1'b0}}, shifted[WW-1:0]};
      default: dout = shifted;
    endcase
  end
endmodule

// File: rtl/aliasreg_pair_check.sv
`timescale 1ns/1ps
module aliasreg_pair_check #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] code_a,
  input  logic [CW-1:0] code_b,
  output logic          err
);
  logic [1:0] is_hi, is_bad, needs_pfx;
  logic [CW-1:0] codes [2];

  assign codes[0] = code_a;
  assign codes[1] = code_b;

  for (genvar g = 0; g < 2; g++) begin : g_op
    assign is_hi[g]     = codes[g][CW-1] && (codes[g][CW-2:2] == '0);
    assign is_bad[g]    = codes[g][CW-1] && (codes[g][CW-2:2] != '0);
    assign needs_pfx[g] = !codes[g][CW-1] && (codes[g][CW-2:2] != '0);
  end

  assign err = (|is_bad) || (is_hi[0] && needs_pfx[1]) || (is_hi[1] && needs_pfx[0]);
endmodule

// File: rtl/aliasreg_file.sv
`timescale 1ns/1ps
module aliasreg_file #(
  parameter int NREG = 16,
  parameter int DW   = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [1:0]               wr_size,
  input  logic                     wr_pfx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(NREG)-1:0]  rd_idx,
  input  logic [1:0]               rd_size,
  input  logic                     rd_pfx,
  output logic [DW-1:0]            rd_data,
  input  logic [$clog2(NREG):0]    chk_a,
  input  logic [$clog2(NREG):0]    chk_b,
  output logic                     chk_err
);
  import aliasreg_pkg::*;
  localparam int IDX_W = $clog2(NREG);

  logic [DW-1:0]    mem [NREG];
  logic [IDX_W-1:0] wr_reg, rd_reg;
  logic             wr_hi, rd_hi;
  logic [DW-1:0]    wr_new, rd_raw;

  aliasreg_decode #(.IDX_W(IDX_W)) u_wdec (
    .idx(wr_idx), .size(wr_size), .pfx(wr_pfx), .reg_sel(wr_reg), .hi(wr_hi));

  aliasreg_decode #(.IDX_W(IDX_W)) u_rdec (
    .idx(rd_idx), .size(rd_size), .pfx(rd_pfx), .reg_sel(rd_reg), .hi(rd_hi));

  aliasreg_merge #(.DW(DW)) u_merge (
    .old_val(mem[wr_reg]), .din(wr_data), .size(wr_size), .hi(wr_hi), .new_val(wr_new));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_reg] <= wr_new;
    end
  end

  // same-cycle forwarding of the pending write
  assign rd_raw = (wr_en && wr_reg == rd_reg) ? wr_new : mem[rd_reg];

  aliasreg_align #(.DW(DW)) u_align (
    .raw(rd_raw), .size(rd_size), .hi(rd_hi), .dout(rd_data));

  aliasreg_pair_check #(.CW(IDX_W+1)) u_chk (
    .code_a(chk_a), .code_b(chk_b), .err(chk_err));

  // ---------------- assertions ----------------
  for (genvar i = 0; i < NREG; i++) begin : g_prop
    p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> mem[i] == '0);
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && wr_reg == IDX_W'(i)) |=> $stable(mem[i]));
    p_zero_fill_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_reg == IDX_W'(i) && size_e'(wr_size) == SZ32) |=> mem[i][DW-1:32] == '0);
    p_forward_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_reg == IDX_W'(i) && rd_reg == IDX_W'(i) && size_e'(rd_size) == SZ64)
      |=> mem[i] == $past(rd_data));
  end

  p_hi_legacy_only_r2: assert property (@(posedge clk) disable iff (rst)
    rd_hi |-> (!rd_pfx && rd_reg < IDX_W'(LEGACY_HI_REGS)));
  p_byte_zext_r5: assert property (@(posedge clk) disable iff (rst)
    (size_e'(rd_size) == SZ8) |-> rd_data[DW-1:8] == '0);
  p_word32_zext_r5: assert property (@(posedge clk) disable iff (rst)
    (size_e'(rd_size) == SZ32) |-> rd_data[DW-1:32] == '0);
  p_low_pair_ok_r9: assert property (@(posedge clk) disable iff (rst)
    (!chk_a[IDX_W] && !chk_b[IDX_W]) |-> !chk_err);
endmodule

// File: tb/tb_aliasreg_file.sv
`timescale 1ns/1ps
module tb_aliasreg_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_pfx = 1'b0, rd_pfx = 1'b0;
  logic [3:0]  wr_idx = '0, rd_idx = '0;
  logic [1:0]  wr_size = '0, rd_size = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic [4:0]  chk_a = '0, chk_b = '0;
  logic        chk_err;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  aliasreg_file dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
    .wr_pfx(wr_pfx), .wr_data(wr_data), .rd_idx(rd_idx), .rd_size(rd_size),
    .rd_pfx(rd_pfx), .rd_data(rd_data), .chk_a(chk_a), .chk_b(chk_b), .chk_err(chk_err));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] idx, input logic [1:0] sz, input logic p,
                       input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_size = sz; wr_pfx = p; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] idx, input logic [1:0] sz, input logic p,
                       output logic [63:0] v);
    @(negedge clk);
    rd_idx = idx; rd_size = sz; rd_pfx = p;
    #1 v = rd_data;
  endtask

  task automatic t_reset_state;
    logic [63:0] v;
    for (int i = 0; i < 16; i++) begin
      do_rd(4'(i), 2'd3, 1'b1, v);
      check("R1 reset clear", v, 64'h0);
    end
  endtask

  task automatic t_wide;
    logic [63:0] v;
    do_wr(4'd5, 2'd3, 1'b1, 64'h1122334455667788);
    do_rd(4'd5, 2'd3, 1'b1, v); check("R7 64-bit write", v, 64'h1122334455667788);
    do_rd(4'd5, 2'd2, 1'b1, v); check("R5 32-bit read", v, 64'h55667788);
    do_rd(4'd5, 2'd1, 1'b1, v); check("R5 16-bit read", v, 64'h7788);
    do_wr(4'd5, 2'd2, 1'b1, 64'hFFFFFFFFAABBCCDD);
    do_rd(4'd5, 2'd3, 1'b1, v); check("R7 32-bit zero fill", v, 64'h00000000AABBCCDD);
  endtask

  task automatic t_legacy_bytes;
    logic [63:0] v;
    do_wr(4'd0, 2'd3, 1'b0, 64'h0123456789ABCDEF);
    do_wr(4'd4, 2'd0, 1'b0, 64'hFFFFFFFFFFFFFF5A);
    do_rd(4'd0, 2'd3, 1'b0, v); check("R6 high byte write lanes", v, 64'h0123456789AB5AEF);
    do_rd(4'd4, 2'd0, 1'b0, v); check("R4 high byte read shifted", v, 64'h5A);
    do_rd(4'd0, 2'd0, 1'b0, v); check("R2 low byte selector 0", v, 64'hEF);
    do_rd(4'd0, 2'd1, 1'b0, v); check("R5 16-bit read", v, 64'h5AEF);
    do_wr(4'd9, 2'd3, 1'b0, 64'h1111111111111111);
    do_rd(4'd1, 2'd3, 1'b1, v); check("R2 bit3 ignored without prefix", v, 64'h1111111111111111);
    do_rd(4'd9, 2'd3, 1'b1, v); check("R2 reg9 untouched", v, 64'h0);
    do_wr(4'd1, 2'd1, 1'b0, 64'hFFFFFFFFFFFFBEEF);
    do_rd(4'd1, 2'd3, 1'b0, v); check("R6 16-bit write lanes", v, 64'h111111111111BEEF);
  endtask

  task automatic t_prefix_bytes;
    logic [63:0] v;
    do_wr(4'd4, 2'd3, 1'b1, 64'h8877665544332211);
    do_rd(4'd4, 2'd0, 1'b1, v); check("R3 prefixed selector 4 low byte", v, 64'h11);
    do_rd(4'd4, 2'd0, 1'b0, v); check("R2 selector 4 unprefixed is high of reg0", v, 64'h5A);
    do_wr(4'd4, 2'd0, 1'b1, 64'h00000000000000EE);
    do_rd(4'd4, 2'd3, 1'b1, v); check("R3 prefixed byte write reg4", v, 64'h88776655443322EE);
    do_rd(4'd0, 2'd3, 1'b1, v); check("R3 reg0 untouched", v, 64'h0123456789AB5AEF);
    do_wr(4'd12, 2'd0, 1'b1, 64'hABCDEF0123456777);
    do_rd(4'd12, 2'd3, 1'b1, v); check("R3 prefixed byte reg12", v, 64'h77);
  endtask

  task automatic t_forward;
    logic [63:0] v;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_size = 2'd3; wr_pfx = 1'b0; wr_data = 64'hCAFEF00DDEADBEEF;
    rd_idx = 4'd3; rd_size = 2'd3; rd_pfx = 1'b0;
    #1 check("R8 forward 64-bit", rd_data, 64'hCAFEF00DDEADBEEF);
    @(negedge clk);
    wr_idx = 4'd7; wr_size = 2'd0; wr_data = 64'h42;
    #1 check("R8 forward high byte merge", rd_data, 64'hCAFEF00DDEAD42EF);
    rd_idx = 4'd7; rd_size = 2'd0;
    #1 check("R8 forward high byte read", rd_data, 64'h42);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic t_idle;
    logic [63:0] v;
    @(negedge clk);
    wr_idx = 4'd3; wr_size = 2'd3; wr_data = 64'h0;
    repeat (3) @(posedge clk);
    do_rd(4'd3, 2'd3, 1'b0, v); check("R10 no write when idle", v, 64'hCAFEF00DDEAD42EF);
  endtask

  task automatic pair(input logic [4:0] a, input logic [4:0] b, input logic exp);
    @(negedge clk);
    chk_a = a; chk_b = b;
    #1 check("R9 pair check", {63'b0, chk_err}, {63'b0, exp});
  endtask

  task automatic t_pairs;
    pair(5'd16, 5'd12, 1'b1);
    pair(5'd12, 5'd17, 1'b1);
    pair(5'd19, 5'd4, 1'b1);
    pair(5'd0, 5'd12, 1'b0);
    pair(5'd16, 5'd1, 1'b0);
    pair(5'd17, 5'd18, 1'b0);
    pair(5'd3, 5'd15, 1'b0);
    pair(5'd20, 5'd0, 1'b1);
    pair(5'd0, 5'd31, 1'b1);
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    t_reset_state();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset_state();
    t_wide();
    t_legacy_bytes();
    t_prefix_bytes();
    t_forward();
    t_idle();
    t_pairs();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule